// File: doc/BRIEF.md
# Multi-Channel ADC Scan Controller

This block drives an external analog-to-digital converter across four input channels. A host writes one control byte at a fixed address. The byte carries a run flag and one enable flag per channel. While the run flag is set, the controller walks the enabled channels in ascending order. For each channel it pulses a start request to the converter and waits for the converter's done strobe. It then keeps the returned sample in that channel's holding register.

Clearing the run flag freezes the holding registers so the host can read a consistent set of values. A conversion that is already under way when the flag clears still completes and is stored. Channel 1 acts as the master enable: when it is off, no channel is scanned. Each holding register has a valid flag that shows whether it has ever received a sample since reset.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The control byte is written only when `wr_en` is high and `wr_addr` equals 0xD7; writes to any other address change nothing. In that byte, bit 5 is the run flag and bits 4, 3, 2 and 1 enable channels 1, 2, 3 and 4; bits 7, 6 and 0 are ignored. After reset the run flag is 0 and all channels are disabled.
- R2: Each start is a pulse of one cycle on `conv_start`. `conv_chan` carries the channel number minus one. No further start is issued until `conv_done` has returned for the pending conversion, and the earliest next start is in the cycle after the done cycle.
- R3: Enabled channels are visited in ascending order and inactive channels are skipped. After the highest enabled channel the scan wraps back to channel 1. Each new scan, including one that resumes after a freeze, begins at the lowest enabled channel at or above the one following the last channel that was started.
- R4: While channel 1 is disabled, no start is issued, whatever the enable bits of channels 2 to 4 say.
- R5: While the run flag is 0, no new start is issued. A conversion pending when the flag clears still completes, and its result is stored.
- R6: On the cycle `conv_done` is high for a pending conversion, `conv_data` is stored in that channel's holding register. `rd_data` shows the holding register selected by `rd_chan` (channel number minus one) in the same cycle.
- R7: Each channel's valid flag, shown on `rd_valid`, is 0 after reset. It becomes 1 when that channel's first conversion completes and stays 1.
- R8: A `conv_done` pulse that arrives while no conversion is pending has no effect on any holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 8 | Host register write address |
| wr_data | input | 8 | Host register write data |
| conv_start | output | 1 | One-cycle conversion request to the converter |
| conv_chan | output | 2 | Channel for the request (channel number minus one) |
| conv_done | input | 1 | Converter reports a finished conversion |
| conv_data | input | 10 | Converted sample |
| rd_chan | input | 2 | Holding register to read (channel number minus one) |
| rd_data | output | 10 | Selected holding register contents |
| rd_valid | output | 1 | Selected channel has received a sample since reset |

## Verification
On every cycle, the assertions check the following properties. A start lasts one cycle, is issued only while running with channel 1 enabled, and names an enabled channel. No start appears while a conversion is pending. Valid flags only rise on a completed conversion and never fall.

Other behaviour shows only in the bench scenarios. These cover the visiting order across different enable masks, the wrap point, and the resume position after a freeze. They also cover the completion of an in-flight conversion after the run flag clears, the writes ignored at other addresses, and stray done pulses that must leave the stored values unchanged.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef struct packed {
        logic              run;
        logic [NUM_CH-1:0] act;
    } scan_cfg_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } scan_state_t;

    // Lowest enabled channel at or above 'from', wrapping around.
    function automatic logic [CH_W-1:0] next_active(input logic [NUM_CH-1:0] mask,
                                                    input logic [CH_W-1:0]   from);
        logic [CH_W-1:0] pick;
        logic [CH_W-1:0] idx;
        pick = from;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            idx = from + CH_W'(k);
            if (mask[idx]) pick = idx;
        end
        return pick;
    endfunction

endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
    import adc_scan_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              run,
    output logic [NUM_CH-1:0] eff_act
);
    localparam int RUN_BIT = 5;
    localparam int CH1_BIT = 4;

    scan_cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en && wr_addr == CTRL_ADDR) begin
            cfg.run <= wr_data[RUN_BIT];
            for (int i = 0; i < NUM_CH; i++) begin
                cfg.act[i] <= wr_data[CH1_BIT - i];
            end
        end
    end

    // Channel 1 gates every other channel.
    always_comb begin
        run     = cfg.run;
        eff_act = cfg.act[0] ? cfg.act : '0;
    end

    a_r4_master_gate: assert property (@(posedge clk) disable iff (rst)
        (eff_act != '0) |-> eff_act[0]);

endmodule

// File: rtl/scan_sched.sv
module scan_sched
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [NUM_CH-1:0] eff_act,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic              store_en,
    output logic [CH_W-1:0]   store_chan
);
    scan_state_t     state;
    logic [CH_W-1:0] cur;
    logic [CH_W-1:0] ptr;
    logic [CH_W-1:0] sel;
    logic            go;

    always_comb begin
        sel        = next_active(eff_act, ptr);
        go         = (state == S_IDLE) && run && (eff_act != '0);
        conv_start = go;
        conv_chan  = (state == S_IDLE) ? sel : cur;
        store_en   = (state == S_WAIT) && conv_done;
        store_chan = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
            ptr   <= '0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    state <= S_WAIT;
                    cur   <= sel;
                end
                S_WAIT: if (conv_done) begin
                    state <= S_IDLE;
                    ptr   <= cur + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: a start is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
    // R2: nothing new starts while one is pending
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> !conv_start);
    // R3: only an enabled channel is requested
    a_r3_active_only: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> eff_act[conv_chan]);
    // R5: no start while frozen
    a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
        !run |-> !conv_start);

endmodule

// File: rtl/scan_result_store.sv
module scan_result_store
    import adc_scan_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_en,
    input  logic [CH_W-1:0]  store_chan,
    input  logic [RES_W-1:0] store_data,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_valid
);
    logic [RES_W-1:0] hold  [NUM_CH];
    logic [NUM_CH-1:0] valid;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                hold[g]  <= '0;
                valid[g] <= 1'b0;
            end else if (store_en && store_chan == CH_W'(g)) begin
                hold[g]  <= store_data;
                valid[g] <= 1'b1;
            end
        end

        // R7: valid is sticky
        a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
            valid[g] |=> valid[g]);
        // R7: valid only rises on a completed conversion
        a_r7_valid_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(valid[g]) |-> $past(store_en && store_chan == CH_W'(g)));
        // R6: contents only change on a store for this channel
        a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
            !(store_en && store_chan == CH_W'(g)) |=> $stable(hold[g]));
    end

    always_comb begin
        rd_data  = hold[rd_chan];
        rd_valid = valid[rd_chan];
    end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD7,
    parameter int                RES_W     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [RES_W-1:0]  rd_data,
    output logic              rd_valid
);
    logic              run;
    logic [NUM_CH-1:0] eff_act;
    logic              store_en;
    logic [CH_W-1:0]   store_chan;

    scan_cfg_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run     (run),
        .eff_act (eff_act)
    );

    scan_sched u_sched (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .eff_act    (eff_act),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .store_en   (store_en),
        .store_chan (store_chan)
    );

    scan_result_store #(.RES_W(RES_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .store_en   (store_en),
        .store_chan (store_chan),
        .store_data (conv_data),
        .rd_chan    (rd_chan),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       conv_start;
    logic [1:0] conv_chan;
    logic       m_done = 1'b0;
    logic       s_done = 1'b0;
    logic       conv_done;
    logic [9:0] m_data = '0;
    logic [9:0] s_data = '0;
    logic [9:0] conv_data;
    logic [1:0] rd_chan = '0;
    logic [9:0] rd_data;
    logic       rd_valid;

    assign conv_done = m_done | s_done;
    assign conv_data = s_done ? s_data : m_data;

    always #10 clk = ~clk;

    adc_scan_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .rd_chan(rd_chan), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int checks = 0;
    int fails  = 0;
    int start_cnt = 0;
    int handled   = 0;
    int seq       = 0;
    logic [1:0] exp_q[$];
    logic [1:0] bptr = '0;
    logic [9:0] exp_data [4];
    logic [3:0] exp_valid = '0;
    logic [1:0] last_chan = '0;
    logic       prev_start = 1'b0;
    bit         done_flag = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] nxt(input logic [3:0] mask, input logic [1:0] from);
        for (int k = 0; k < 4; k++) begin
            if (mask[2'(from + 2'(k))]) return 2'(from + 2'(k));
        end
        return from;
    endfunction

    function automatic logic [7:0] ctrl_byte(input bit run, input logic [3:0] mask);
        return {2'b01, run, mask[0], mask[1], mask[2], mask[3], 1'b0};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: push the expected visiting order, run, then freeze (R3, R5).
    task automatic run_scan(input logic [3:0] mask, input int n);
        int s0;
        for (int i = 0; i < n; i++) begin
            logic [1:0] c;
            c = nxt(mask, bptr);
            exp_q.push_back(c);
            bptr = c + 2'd1;
        end
        wr(8'hD7, ctrl_byte(1'b1, mask));
        while (exp_q.size() != 0) @(negedge clk);
        wr(8'hD7, ctrl_byte(1'b0, mask));
        s0 = start_cnt;
        repeat (12) @(negedge clk);
        check(start_cnt == s0, "R5 no start after freeze", start_cnt - s0, 0);
        check(start_cnt == handled, "R2 starts vs handled", start_cnt, handled);
        rd_chan = last_chan;
        #1;
        check(rd_data == exp_data[last_chan], "R5 in-flight result stored",
              rd_data, exp_data[last_chan]);
    endtask

    // Converter model and scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            m_done = 1'b0;
            if (conv_start) begin
                logic [1:0] c;
                int lat;
                c = conv_chan;
                handled++;
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected start", c, -1);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check(c == e, "R3 channel order", c, e);
                end
                lat = 1 + (seq % 3);
                repeat (lat) @(negedge clk);
                m_data = 10'((seq * 37 + int'(c) + 1) & 10'h3FF);
                seq++;
                m_done = 1'b1;
                exp_data[c] = m_data;
                exp_valid[c] = 1'b1;
                last_chan = c;
            end
        end
    end

    // Count starts and check pulse width (R2).
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                start_cnt++;
                check(!prev_start, "R2 single-cycle start", 1, 0);
            end
            prev_start = conv_start;
        end
    end

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int s0;
        for (int i = 0; i < 4; i++) exp_data[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R7 reset state
        check(conv_start == 1'b0, "R1 reset no start", conv_start, 0);
        for (int i = 0; i < 4; i++) begin
            rd_chan = 2'(i);
            #1;
            check(rd_valid == 1'b0, "R7 valid clear after reset", rd_valid, 0);
        end

        // R1: write to another address is ignored
        s0 = start_cnt;
        wr(8'hD6, 8'h7E);
        repeat (10) @(negedge clk);
        check(start_cnt == s0, "R1 other address ignored", start_cnt - s0, 0);

        // R7: only channel 1 converts
        run_scan(4'b0001, 3);
        for (int i = 0; i < 4; i++) begin
            rd_chan = 2'(i);
            #1;
            check(rd_valid == exp_valid[i], "R7 valid per channel", rd_valid, exp_valid[i]);
        end

        // R3: all channels, wrap
        run_scan(4'b1111, 9);
        // R6: every holding register
        for (int i = 0; i < 4; i++) begin
            rd_chan = 2'(i);
            #1;
            check(rd_data == exp_data[i], "R6 stored result", rd_data, exp_data[i]);
            check(rd_valid == 1'b1, "R7 valid set", rd_valid, 1);
        end

        // R3: skip channel 3
        run_scan(4'b1011, 7);

        // R4: channel 1 off gates the rest
        s0 = start_cnt;
        wr(8'hD7, ctrl_byte(1'b1, 4'b1110));
        repeat (15) @(negedge clk);
        check(start_cnt == s0, "R4 channel 1 gate", start_cnt - s0, 0);
        wr(8'hD7, ctrl_byte(1'b0, 4'b1110));

        // R8: stray done while idle
        s_data = 10'h155;
        s_done = 1'b1;
        @(negedge clk);
        s_done = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd_chan = 2'(i);
            #1;
            check(rd_data == exp_data[i], "R8 stray done ignored", rd_data, exp_data[i]);
        end

        // R3: resume position after freeze
        run_scan(4'b1111, 5);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule